// File: doc/BRIEF.md
# Two-Row Sorted Priority Queue

This block stores (key, value) pairs and always shows the value whose key is smallest. Keys are compared as unsigned numbers. A user pulses `insert` with a key and value to add a pair, or pulses `remove` to drop the pair with the smallest key. The block keeps no sorted list and does no search. Storage is two rows of cells, an upper row and a lower row. Each cell holds a present flag, a key and a value.

Every accepted operation takes two clock edges.

- **Insert.** On the first edge the upper row moves one cell to the right, and the new pair enters the leftmost upper cell.
- **Remove.** On the first edge the lower row moves one cell to the left, and the rightmost lower cell becomes empty.
- **Second edge, both operations.** Every column compares its two cells at once. The upper cell moves down when it is occupied and either its key is smaller or the lower cell is empty.

The controller has three named states: `PQ_READY`, `PQ_INSERTING` and `PQ_DELETING`.

| From | Condition | To |
|---|---|---|
| `PQ_READY` | insert strobe while the upper row has room | `PQ_INSERTING` |
| `PQ_READY` | remove strobe with no insert strobe, while the queue holds data | `PQ_DELETING` |
| `PQ_INSERTING` | always | `PQ_READY` |
| `PQ_DELETING` | always | `PQ_READY` |

In every other case the controller stays in `PQ_READY`. The `busy` flag is high in both non-ready states.

With `COLS` columns, the queue holds up to 2·`COLS` pairs.

Top module: `pq_sorted_queue`

## Requirements
- R1: After synchronous reset the outputs are `empty`=1, `full`=0, `busy`=0 and `min_value`=0.
- R2: An insert strobe seen in ready while `full`=0 is accepted, and the pair is stored.
- R3: A remove strobe seen in ready, with `insert` low and `empty`=0, is accepted. It removes the stored pair with the smallest unsigned key.
- R4: When the controller is ready, `min_value` is the value paired with the smallest stored unsigned key. It is 0 when the queue is empty.
- R5: `empty` is 1 exactly when no pair is stored.
- R6: `full` is 1 exactly when 2·`COLS` pairs are stored. An insert strobe while `full`=1 leaves the contents unchanged.
- R7: A remove strobe while `empty`=1 leaves the queue unchanged.
- R8: Insert and remove strobes that arrive while `busy`=1 are ignored.
- R9: If `insert` and `remove` are both high in ready, only the insert takes effect.
- R10: `busy` is high for exactly the one cycle after an accepted strobe, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| insert | input | 1 | Insert strobe |
| remove | input | 1 | Remove-smallest strobe |
| in_key | input | KEY_W | Key of the pair to insert |
| in_value | input | VAL_W | Value of the pair to insert |
| min_value | output | VAL_W | Value paired with the smallest key, 0 when empty |
| busy | output | 1 | High while the column compare-and-swap is pending |
| empty | output | 1 | No pair stored |
| full | output | 1 | Upper row full, so 2·COLS pairs stored |

## Verification
The bench builds the block with its default parameters: four columns and 4-bit keys and values. That gives a capacity of eight pairs drawn from sixteen possible keys. Because keys are distinct, random traffic can reach both the full and the empty boundaries many times. It can also mix every interleaving of upper-row and lower-row occupancy. A software model of the stored set predicts the smallest-key value after each operation.

// File: rtl/pq_pkg.sv
package pq_pkg;
    typedef enum logic [1:0] {
        PQ_READY     = 2'd0,
        PQ_INSERTING = 2'd1,
        PQ_DELETING  = 2'd2
    } pq_state_e;
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ins_req,
    input  logic del_req,
    input  logic room_ok,
    input  logic data_ok,
    output logic shift_up_row,
    output logic shift_lo_row,
    output logic col_swap,
    output logic busy
);
    pq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PQ_READY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        shift_up_row = 1'b0;
        shift_lo_row = 1'b0;
        col_swap     = 1'b0;
        busy         = 1'b0;
        unique case (state_q)
            PQ_READY: begin
                if (ins_req) begin
                    if (room_ok) begin
                        shift_up_row = 1'b1;
                        state_d      = PQ_INSERTING;
                    end
                end else if (del_req && data_ok) begin
                    shift_lo_row = 1'b1;
                    state_d      = PQ_DELETING;
                end
            end
            PQ_INSERTING, PQ_DELETING: begin
                busy     = 1'b1;
                col_swap = 1'b1;
                state_d  = PQ_READY;
            end
            default: state_d = PQ_READY;
        endcase
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_q inside {PQ_READY, PQ_INSERTING, PQ_DELETING}); // R10
    AST_SWAP_RETURNS: assert property (@(posedge clk) disable iff (rst)
        col_swap |=> (state_q == PQ_READY)); // R10
endmodule

// File: rtl/pq_col_swap.sv
module pq_col_swap #(
    parameter int KEY_W = 4
) (
    input  logic             up_dp,
    input  logic [KEY_W-1:0] up_key,
    input  logic             lo_dp,
    input  logic [KEY_W-1:0] lo_key,
    output logic             swap_en
);
    always_comb begin
        swap_en = up_dp && (!lo_dp || (up_key < lo_key));
    end
endmodule

// File: rtl/pq_sorted_queue.sv
module pq_sorted_queue #(
    parameter int COLS  = 4,
    parameter int KEY_W = 4,
    parameter int VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insert,
    input  logic             remove,
    input  logic [KEY_W-1:0] in_key,
    input  logic [VAL_W-1:0] in_value,
    output logic [VAL_W-1:0] min_value,
    output logic             busy,
    output logic             empty,
    output logic             full
);
    localparam int LAST = COLS - 1;

    logic             up_dp  [COLS];
    logic [KEY_W-1:0] up_key [COLS];
    logic [VAL_W-1:0] up_val [COLS];
    logic             lo_dp  [COLS];
    logic [KEY_W-1:0] lo_key [COLS];
    logic [VAL_W-1:0] lo_val [COLS];
    logic [COLS-1:0]  swap_vec;

    logic shift_up_row, shift_lo_row, col_swap;

    pq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ins_req      (insert),
        .del_req      (remove),
        .room_ok      (!up_dp[LAST]),
        .data_ok      (lo_dp[0]),
        .shift_up_row (shift_up_row),
        .shift_lo_row (shift_lo_row),
        .col_swap     (col_swap),
        .busy         (busy)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        pq_col_swap #(.KEY_W(KEY_W)) u_swap (
            .up_dp   (up_dp[c]),
            .up_key  (up_key[c]),
            .lo_dp   (lo_dp[c]),
            .lo_key  (lo_key[c]),
            .swap_en (swap_vec[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COLS; i++) begin
                up_dp[i] <= 1'b0;
                lo_dp[i] <= 1'b0;
            end
        end else if (shift_up_row) begin
            for (int i = 1; i < COLS; i++) begin
                up_dp[i]  <= up_dp[i-1];
                up_key[i] <= up_key[i-1];
                up_val[i] <= up_val[i-1];
            end
            up_dp[0]  <= 1'b1;
            up_key[0] <= in_key;
            up_val[0] <= in_value;
        end else if (shift_lo_row) begin
            for (int i = 0; i < LAST; i++) begin
                lo_dp[i]  <= lo_dp[i+1];
                lo_key[i] <= lo_key[i+1];
                lo_val[i] <= lo_val[i+1];
            end
            lo_dp[LAST] <= 1'b0;
        end else if (col_swap) begin
            for (int i = 0; i < COLS; i++) begin
                if (swap_vec[i]) begin
                    up_dp[i]  <= lo_dp[i];
                    up_key[i] <= lo_key[i];
                    up_val[i] <= lo_val[i];
                    lo_dp[i]  <= up_dp[i];
                    lo_key[i] <= up_key[i];
                    lo_val[i] <= up_val[i];
                end
            end
        end
    end

    always_comb begin
        min_value = lo_dp[0] ? lo_val[0] : '0;
        empty     = !lo_dp[0];
        full      = up_dp[LAST];
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (empty && !full && !busy)); // R1
    AST_INS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!busy && insert && !full) |=> busy); // R2
    AST_DEL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!busy && remove && !insert && !empty) |=> busy); // R3
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        empty |-> (min_value == '0)); // R4
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        full |-> !empty); // R6
    AST_DEL_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!busy && !insert && empty) |=> (empty && !busy)); // R7
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !insert && !remove) |=> ($stable(min_value) && $stable(empty) && $stable(full))); // R8
endmodule

// File: tb/pq_sorted_queue_tb.sv
`timescale 1ns/1ps
module pq_sorted_queue_tb_top;
    localparam int COLS = 4;
    localparam int KW   = 4;
    localparam int VW   = 4;
    localparam int CAP  = 2 * COLS;

    logic clk = 1'b0;
    logic rst, insert, remove;
    logic [KW-1:0] in_key;
    logic [VW-1:0] in_value;
    logic [VW-1:0] min_value;
    logic busy, empty, full;

    int n_chk = 0;
    int n_bad = 0;

    int mk [CAP];
    int mv [CAP];
    int mcount = 0;

    always #10 clk = ~clk;

    pq_sorted_queue #(.COLS(COLS), .KEY_W(KW), .VAL_W(VW)) dut_i (
        .clk(clk), .rst(rst), .insert(insert), .remove(remove),
        .in_key(in_key), .in_value(in_value), .min_value(min_value),
        .busy(busy), .empty(empty), .full(full)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_min_idx();
        int best = -1;
        for (int i = 0; i < mcount; i++)
            if (best < 0 || mk[i] < mk[best]) best = i;
        return best;
    endfunction

    function automatic int model_min_val();
        int b = model_min_idx();
        return (b < 0) ? 0 : mv[b];
    endfunction

    function automatic bit key_used(input int k);
        for (int i = 0; i < mcount; i++)
            if (mk[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int fresh_key();
        int k;
        do k = int'($urandom % 16); while (key_used(k));
        return k;
    endfunction

    task automatic check_state(input string tag);
        check({tag, " R4 min_value"}, int'(min_value), model_min_val());
        check({tag, " R5 empty"}, int'(empty), int'(mcount == 0));
        check({tag, " R6 full"}, int'(full), int'(mcount == CAP));
    endtask

    // One operation: strobe for one clock, junk strobe during busy (R8), then check.
    task automatic op(input bit ins, input bit del, input int k, input int v, input string tag);
        bit acc_i, acc_d;
        int b;
        @(negedge clk);
        insert = ins; remove = del; in_key = KW'(k); in_value = VW'(v);
        acc_i = ins && (mcount < CAP);
        acc_d = !ins && del && (mcount > 0);
        @(negedge clk);
        check({tag, " R10 busy after strobe"}, int'(busy), int'(acc_i || acc_d));
        if (acc_i || acc_d) begin
            insert = $urandom % 2; remove = $urandom % 2;
            in_key = KW'($urandom); in_value = VW'($urandom);
            @(negedge clk);
        end
        insert = 1'b0; remove = 1'b0;
        if (acc_i) begin
            mk[mcount] = k; mv[mcount] = v; mcount++;
        end else if (acc_d) begin
            b = model_min_idx();
            mk[b] = mk[mcount-1]; mv[b] = mv[mcount-1]; mcount--;
        end
        check({tag, " R10 busy cleared"}, int'(busy), 0);
        check_state(tag);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd20240611));
        rst = 1'b1; insert = 1'b0; remove = 1'b0; in_key = '0; in_value = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 min_value", int'(min_value), 0);
        // R7 remove on empty
        op(1'b0, 1'b1, 0, 0, "R7 remove-empty");
        // R2/R6 fill in descending key order
        for (int i = 0; i < CAP; i++) op(1'b1, 1'b0, 15 - i, (i * 3 + 1) % 16, "R2 fill");
        check("R6 full after fill", int'(full), 1);
        op(1'b1, 1'b0, 0, 9, "R6 insert-full");
        // R3 drain
        for (int i = 0; i < CAP; i++) op(1'b0, 1'b1, 0, 0, "R3 drain");
        // R9 both strobes
        op(1'b1, 1'b1, 5, 11, "R9 both-empty");
        op(1'b1, 1'b1, 2, 6, "R9 both");
        op(1'b0, 1'b1, 0, 0, "R3 remove");
        op(1'b0, 1'b1, 0, 0, "R3 remove");
        // Ascending fill then random traffic
        for (int i = 0; i < CAP; i++) op(1'b1, 1'b0, i, 15 - i, "R2 ascend");
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 8);
            if (r < 4) begin
                k = (mcount < CAP) ? fresh_key() : int'($urandom % 16);
                op(1'b1, (r == 0), k, int'($urandom % 16), "R4 random ins");
            end else begin
                op(1'b0, 1'b1, 0, 0, "R4 random del");
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule